// File: doc/BRIEF.md
# Nested Priority Interrupt Sequencer

This block is the control unit that takes exceptions and external interrupts for a small processor core. It tracks whether interrupts are disabled, enabled or being served. It decides whether each request is taken, ignored or fatal. It then runs the entry or exit sequence one memory cycle at a time, while the core stays stalled on `busy`.

On entry the block saves argument registers and a packed return word on a stack that grows downward. It then jumps to a vector whose address equals the request kind. On return it unwinds the same frame and resumes whichever preempted kind is left. The register file and the stack memory sit outside the block. The block reads and writes both through plain ports: a combinational register read port, and a stack memory with one cycle of read latency.

The block accepts one command per idle cycle, in this order of precedence: return, exception, disable, enable, external check. Kinds are numbered as follows. 1 is external, 2 is software, 3 is divide-by-zero, 4 is bad memory access, 5 is unsupported opcode and 6 is illegal opcode.

Top module: `irq_seq`

## Requirements
- R1: After reset `irq_state` is 0 (disabled), `busy` and `fatal` are 0, `sp` equals the stack top (64), and no pending bits are set; `irq_state` encodes 0 disabled, 1 enabled, 2 serving.
- R2: While serving kind K, a request of kind greater than K is taken, and bit K is added to `irq_nest`. A request of kind K or lower is ignored, with no stack or register activity. `irq_nest` never holds a bit at or above the kind being served.
- R3: Entry with N arguments does the following. It writes register i to address `sp-1-i` and replaces register i with argument i, for i from 0 to N-1. It then writes the word `{N[31:28], return pc[27:0]}` below them, leaves `sp` N+1 lower, and loads the PC with the kind number. `busy` is high for N+1 cycles.
- R4: Return reads the top word and loads its bits 27:0 as the PC. It pops N (bits 31:28) further words into registers N-1 down to 0 and restores `sp`. `busy` is high for N+2 cycles.
- R5: On return while serving, the highest bit set in `irq_nest` becomes the served kind and that bit is cleared. If the nest mask is empty, the state becomes enabled.
- R6: When the kind being left is 3 or 5, after the unwind the value that register 1 held at the return is written to the register whose index register 0 held (bits 3:0). Other kinds do no such write.
- R7: External pending bits are examined only in the enabled state, and only in a cycle with no higher-precedence command. If any pending bit lies outside the enable mask, all pending bits are cleared. Otherwise kind 1 is entered with one argument, the index of the highest set pending bit.
- R8: Returning from kind 1 clears all pending bits and puts the block in the enabled state.
- R9: An exception in the disabled state sets `fatal`, which stays set until reset; no frame is built.
- R10: Disable sets the disabled state and clears the enable mask and every pending bit. Enable acts only from the disabled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_req | input | 1 | Exception request from the core |
| exc_kind | input | 3 | Exception kind number |
| exc_argc | input | 2 | Number of arguments (0 to 3) |
| exc_args | input | 96 | Arguments, argument i in bits 32i+31:32i |
| ret_pc | input | 28 | Address at which to resume after the handler |
| ext_raise | input | 4 | Sets external pending bits |
| mask_we | input | 1 | Loads the external enable mask |
| mask_wdata | input | 4 | New enable mask |
| en_cmd | input | 1 | Enable interrupts |
| dis_cmd | input | 1 | Disable interrupts |
| reti_req | input | 1 | Return from interrupt |
| rf_raddr | output | 4 | Register read index |
| rf_rdata | input | 32 | Register read data (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mem_en | output | 1 | Stack memory access |
| mem_we | output | 1 | Stack memory write |
| mem_addr | output | 8 | Stack word address |
| mem_wdata | output | 32 | Stack write data |
| mem_rdata | input | 32 | Stack read data, one cycle after the access |
| pc_load | output | 1 | Load `pc_new` into the PC |
| pc_new | output | 28 | New PC value |
| sp | output | 8 | Stack pointer (word address of the top word) |
| busy | output | 1 | Sequence in progress; the core stalls |
| fatal | output | 1 | Fatal halt |
| irq_state | output | 2 | 0 disabled, 1 enabled, 2 serving |
| irq_kind | output | 3 | Kind being served |
| irq_nest | output | 8 | Preempted kinds |
| ext_pending | output | 4 | External pending bits |

## Verification
Commands, state changes and pending clears show up at the first clock edge after the cycle in which they are presented. The bench drives at falling edges and reads back at the next falling edge. An entry holds `busy` for N+1 cycles and a return for N+2. The bench counts those cycles at falling edges from the accept edge onward, and compares the count, the last PC loaded, the stack words and the registers only after `busy` drops. An external request needs one edge to become pending and one more to be accepted, so the bench waits for `busy` before it starts counting. Where a request must be dropped or ignored, the bench waits three edges and then checks pending bits, state and `sp`.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int RA = 4,
  parameter int KW = 3,
  parameter int MAXARG = 3,
  parameter int NSRC = 4,
  parameter int STACK_TOP = 64,
  parameter int KIND_EXT = 1,
  parameter int KIND_DIV = 3,
  parameter int KIND_UNSUP = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  exc_req,
  input  logic [KW-1:0]         exc_kind,
  input  logic [$clog2(MAXARG+1)-1:0] exc_argc,
  input  logic [MAXARG*DW-1:0]  exc_args,
  input  logic [DW-5:0]         ret_pc,
  input  logic [NSRC-1:0]       ext_raise,
  input  logic                  mask_we,
  input  logic [NSRC-1:0]       mask_wdata,
  input  logic                  en_cmd,
  input  logic                  dis_cmd,
  input  logic                  reti_req,
  output logic [RA-1:0]         rf_raddr,
  input  logic [DW-1:0]         rf_rdata,
  output logic                  rf_we,
  output logic [RA-1:0]         rf_waddr,
  output logic [DW-1:0]         rf_wdata,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  pc_load,
  output logic [DW-5:0]         pc_new,
  output logic [AW-1:0]         sp,
  output logic                  busy,
  output logic                  fatal,
  output logic [1:0]            irq_state,
  output logic [KW-1:0]         irq_kind,
  output logic [(1<<KW)-1:0]    irq_nest,
  output logic [NSRC-1:0]       ext_pending
);
  localparam int PCW = DW - 4;
  localparam int NW  = 4;
  localparam int MW  = 1 << KW;
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [1:0] ST_DIS = 2'd0, ST_EN = 2'd1, ST_SRV = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_RETW, S_RWORD, S_POP, S_FIX} seq_t;

  seq_t                seq;
  logic [1:0]          st;
  logic [KW-1:0]       kind, kind_q;
  logic [MW-1:0]       nest;
  logic [NSRC-1:0]     pend, mask;
  logic [AW-1:0]       sp_q;
  logic                fatal_q, fix_en;
  logic [NW-1:0]       idx, n_q;
  logic [MAXARG*DW-1:0] args_q;
  logic [PCW-1:0]      pc_q;
  logic [RA-1:0]       fix_idx;
  logic [DW-1:0]       fix_val, arg_sel;

  function automatic logic [IW-1:0] top_pend(input logic [NSRC-1:0] v);
    top_pend = '0;
    for (int i = 0; i < NSRC; i++) if (v[i]) top_pend = IW'(i);
  endfunction

  function automatic logic [KW-1:0] top_nest(input logic [MW-1:0] v);
    top_nest = '0;
    for (int i = 0; i < MW; i++) if (v[i]) top_nest = KW'(i);
  endfunction

  wire idle      = (seq == S_IDLE);
  wire do_reti   = idle & reti_req;
  wire do_exc    = idle & ~reti_req & exc_req;
  wire exc_fatal = do_exc & (st == ST_DIS);
  wire exc_take  = do_exc & ((st == ST_EN) | ((st == ST_SRV) & (exc_kind > kind)));
  wire do_dis    = idle & ~reti_req & ~exc_req & dis_cmd;
  wire do_en     = idle & ~reti_req & ~exc_req & ~dis_cmd & en_cmd;
  wire ext_ok    = idle & ~reti_req & ~exc_req & ~dis_cmd & ~en_cmd & (st == ST_EN) & (|pend);
  wire ext_drop  = ext_ok & (|(pend & ~mask));
  wire ext_take  = ext_ok & ~(|(pend & ~mask));
  wire take      = exc_take | ext_take;
  wire clr_pend  = do_dis | ext_drop | (do_reti & (st == ST_SRV) & (kind == KW'(KIND_EXT)));

  wire [KW-1:0]         new_kind = exc_take ? exc_kind : KW'(KIND_EXT);
  wire [NW-1:0]         new_n    = exc_take ? NW'(exc_argc) : NW'(1);
  wire [MAXARG*DW-1:0]  new_args = exc_take ? exc_args : (MAXARG*DW)'(top_pend(pend));
  wire [NW-1:0]         word_n   = mem_rdata[DW-1:PCW];
  wire [KW-1:0]         nest_top = top_nest(nest);

  always_comb begin
    arg_sel = '0;
    for (int i = 0; i < MAXARG; i++) if (idx == NW'(i)) arg_sel = args_q[i*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq <= S_IDLE; st <= ST_DIS; kind <= '0; kind_q <= '0; nest <= '0;
      pend <= '0; mask <= '0; sp_q <= AW'(STACK_TOP); fatal_q <= 1'b0;
      fix_en <= 1'b0; idx <= '0; n_q <= '0; args_q <= '0; pc_q <= '0;
      fix_idx <= '0; fix_val <= '0;
    end else begin
      pend <= clr_pend ? '0 : (pend | ext_raise);
      if (do_dis) mask <= '0;
      else if (mask_we) mask <= mask_wdata;
      if (exc_fatal) fatal_q <= 1'b1;
      case (seq)
        S_IDLE: begin
          if (do_reti) begin
            fix_idx <= rf_rdata[RA-1:0];
            fix_en  <= (st == ST_SRV) & ((kind == KW'(KIND_DIV)) | (kind == KW'(KIND_UNSUP)));
            sp_q    <= sp_q + 1'b1;
            seq     <= S_RWORD;
            if (st == ST_SRV) begin
              if (kind == KW'(KIND_EXT) || nest == '0) begin
                st <= ST_EN; nest <= '0; kind <= '0;
              end else begin
                kind <= nest_top;
                nest <= nest & ~(MW'(1) << nest_top);
              end
            end
          end else if (take) begin
            kind_q <= new_kind; n_q <= new_n; args_q <= new_args; pc_q <= ret_pc;
            idx    <= '0;
            seq    <= (new_n == '0) ? S_RETW : S_PUSH;
            if (st == ST_SRV) nest <= nest | (MW'(1) << kind);
            kind   <= new_kind;
            st     <= ST_SRV;
          end else if (do_dis) begin
            st <= ST_DIS; nest <= '0; kind <= '0;
          end else if (do_en && st == ST_DIS) begin
            st <= ST_EN;
          end
        end
        S_PUSH: begin
          sp_q <= sp_q - 1'b1;
          idx  <= idx + 1'b1;
          if (idx == n_q - 1'b1) seq <= S_RETW;
        end
        S_RETW: begin
          sp_q <= sp_q - 1'b1;
          seq  <= S_IDLE;
        end
        S_RWORD: begin
          fix_val <= rf_rdata;
          pc_q    <= mem_rdata[PCW-1:0];
          n_q     <= word_n;
          idx     <= word_n;
          if (word_n != '0) begin
            sp_q <= sp_q + 1'b1;
            seq  <= S_POP;
          end else seq <= S_FIX;
        end
        S_POP: begin
          idx <= idx - 1'b1;
          if (idx > NW'(1)) sp_q <= sp_q + 1'b1;
          else seq <= S_FIX;
        end
        default: seq <= S_IDLE;
      endcase
    end
  end

  assign rf_raddr  = (seq == S_PUSH) ? RA'(idx) : ((seq == S_RWORD) ? RA'(1) : '0);
  assign rf_we     = (seq == S_PUSH) | (seq == S_POP) | ((seq == S_FIX) & fix_en);
  assign rf_waddr  = (seq == S_PUSH) ? RA'(idx) : ((seq == S_POP) ? RA'(idx - 1'b1) : fix_idx);
  assign rf_wdata  = (seq == S_PUSH) ? arg_sel : ((seq == S_POP) ? mem_rdata : fix_val);
  assign mem_we    = (seq == S_PUSH) | (seq == S_RETW);
  assign mem_en    = mem_we | do_reti | ((seq == S_RWORD) & (word_n != '0)) |
                     ((seq == S_POP) & (idx > NW'(1)));
  assign mem_addr  = mem_we ? sp_q - 1'b1 : sp_q;
  assign mem_wdata = (seq == S_PUSH) ? rf_rdata : {n_q, pc_q};
  assign pc_load   = (seq == S_RETW) | (seq == S_FIX);
  assign pc_new    = (seq == S_RETW) ? PCW'(kind_q) : pc_q;
  assign sp          = sp_q;
  assign busy        = ~idle;
  assign fatal       = fatal_q;
  assign irq_state   = st;
  assign irq_kind    = kind;
  assign irq_nest    = nest;
  assign ext_pending = pend;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int AW = 8,
  parameter int KW = 3,
  parameter int NSRC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              fatal,
  input logic              pc_load,
  input logic              mem_we,
  input logic              rf_we,
  input logic [AW-1:0]     sp,
  input logic [1:0]        irq_state,
  input logic [KW-1:0]     irq_kind,
  input logic [(1<<KW)-1:0] irq_nest,
  input logic [NSRC-1:0]   ext_pending,
  input logic              dis_cmd,
  input logic              exc_req,
  input logic              reti_req
);
  assert_fatal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);

  assert_nest_below_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_state == 2'd2) |-> ((irq_nest >> irq_kind) == '0));

  assert_push_descends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == $past(sp) - 1'b1));

  assert_idle_no_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !rf_we));

  assert_pc_load_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  assert_nest_only_serving_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_state != 2'd2) |-> (irq_nest == '0));

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_cmd && !busy && !exc_req && !reti_req) |=> (ext_pending == '0 && irq_state == 2'd0));
endmodule

bind irq_seq irq_seq_chk #(.AW(AW), .KW(KW), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .fatal(fatal), .pc_load(pc_load),
  .mem_we(mem_we), .rf_we(rf_we), .sp(sp), .irq_state(irq_state),
  .irq_kind(irq_kind), .irq_nest(irq_nest), .ext_pending(ext_pending),
  .dis_cmd(dis_cmd), .exc_req(exc_req), .reti_req(reti_req)
);

// File: tb/irq_seq_bench.sv
module irq_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        exc_req = 0, mask_we = 0, en_cmd = 0, dis_cmd = 0, reti_req = 0;
  logic [2:0]  exc_kind = 0;
  logic [1:0]  exc_argc = 0;
  logic [95:0] exc_args = '0;
  logic [27:0] ret_pc = '0;
  logic [3:0]  ext_raise = 0, mask_wdata = 0;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, mem_wdata, mem_rdata;
  logic        rf_we, mem_en, mem_we, pc_load, busy, fatal;
  logic [7:0]  mem_addr, sp, irq_nest;
  logic [27:0] pc_new;
  logic [1:0]  irq_state;
  logic [2:0]  irq_kind;
  logic [3:0]  ext_pending;

  irq_seq u_irq_seq (.*);

  logic [31:0] rf [16];
  logic [31:0] mem [256];
  logic [31:0] mem_q;
  logic [27:0] last_pc;
  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem_q;
  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_en) mem_q <= mem[mem_addr];
    if (pc_load) last_pc <= pc_new;
  end

  int tests = 0, fails = 0, cnt = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic count_busy(output int c);
    c = 0;
    while (busy) begin c++; @(negedge clk); end
  endtask

  task automatic fire_exc(input logic [2:0] k, input logic [1:0] n, input logic [31:0] a0,
                          input logic [31:0] a1, input logic [31:0] a2, input logic [27:0] rpc,
                          output int c);
    @(negedge clk);
    exc_req = 1; exc_kind = k; exc_argc = n; exc_args = {a2, a1, a0}; ret_pc = rpc;
    @(negedge clk);
    exc_req = 0;
    count_busy(c);
  endtask

  task automatic do_reti(output int c);
    @(negedge clk); reti_req = 1;
    @(negedge clk); reti_req = 0;
    count_busy(c);
  endtask

  task automatic pulse_cmd(input bit en);
    @(negedge clk); if (en) en_cmd = 1; else dis_cmd = 1;
    @(negedge clk); en_cmd = 0; dis_cmd = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h1000 + i;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem_q = '0; last_pc = '0;
    do_reset();
    chk("R1 state", irq_state, 0);
    chk("R1 busy", busy, 0);
    chk("R1 fatal", fatal, 0);
    chk("R1 sp", sp, 64);
    chk("R1 pending", ext_pending, 0);

    // R9: exception while disabled
    fire_exc(3'd2, 2'd0, 0, 0, 0, 28'h10, cnt);
    chk("R9 no frame busy", cnt, 0);
    chk("R9 fatal", fatal, 1);
    chk("R9 sp", sp, 64);
    repeat (3) @(negedge clk);
    chk("R9 fatal sticky", fatal, 1);
    do_reset();
    chk("R1 fatal cleared", fatal, 0);

    pulse_cmd(1);
    chk("R10 enable", irq_state, 1);

    // R3 entry kind 3, two args
    fire_exc(3'd3, 2'd2, 32'hAAAA0000, 32'hBBBB1111, 0, 28'h0000123, cnt);
    chk("R3 busy N+1", cnt, 3);
    chk("R3 vector", last_pc, 3);
    chk("R3 sp", sp, 61);
    chk("R3 saved r0", mem[63], 32'h1000);
    chk("R3 saved r1", mem[62], 32'h1001);
    chk("R3 ret word", mem[61], 32'h20000123);
    chk("R3 arg r0", rf[0], 32'hAAAA0000);
    chk("R3 arg r1", rf[1], 32'hBBBB1111);
    chk("R3 state", irq_state, 2);
    chk("R3 kind", irq_kind, 3);
    chk("R2 nest empty", irq_nest, 0);

    // R2 preempt by kind 5, three args
    fire_exc(3'd5, 2'd3, 32'hC0, 32'hC1, 32'hC2, 28'h0000200, cnt);
    chk("R2 preempt busy", cnt, 4);
    chk("R2 vector", last_pc, 5);
    chk("R3 sp nested", sp, 57);
    chk("R3 saved r0 nested", mem[60], 32'hAAAA0000);
    chk("R3 saved r2 nested", mem[58], 32'h1002);
    chk("R3 ret word nested", mem[57], 32'h30000200);
    chk("R3 arg r2", rf[2], 32'hC2);
    chk("R2 kind", irq_kind, 5);
    chk("R2 nest bit3", irq_nest, 8'h08);

    // R2 lower and equal kinds ignored
    fire_exc(3'd2, 2'd1, 32'hDEAD, 0, 0, 28'h77, cnt);
    chk("R2 lower ignored busy", cnt, 0);
    chk("R2 lower ignored sp", sp, 57);
    chk("R2 lower ignored r0", rf[0], 32'hC0);
    fire_exc(3'd5, 2'd1, 32'hDEAD, 0, 0, 28'h77, cnt);
    chk("R2 equal ignored sp", sp, 57);
    chk("R2 equal ignored kind", irq_kind, 5);

    pulse_cmd(1);
    chk("R10 enable ignored while serving", irq_state, 2);

    // R4/R5/R6 return from kind 5 with fix-up
    rf[0] = 32'h7; rf[1] = 32'hBEEF0001;
    do_reti(cnt);
    chk("R4 busy N+2", cnt, 5);
    chk("R4 pc", last_pc, 28'h200);
    chk("R4 sp", sp, 61);
    chk("R4 r0", rf[0], 32'hAAAA0000);
    chk("R4 r1", rf[1], 32'hBBBB1111);
    chk("R4 r2", rf[2], 32'h1002);
    chk("R6 fixup r7", rf[7], 32'hBEEF0001);
    chk("R5 resume kind", irq_kind, 3);
    chk("R5 nest cleared", irq_nest, 0);
    chk("R5 still serving", irq_state, 2);

    rf[0] = 32'h9; rf[1] = 32'h55;
    do_reti(cnt);
    chk("R4 busy N+2 second", cnt, 4);
    chk("R4 pc second", last_pc, 28'h123);
    chk("R4 sp restored", sp, 64);
    chk("R4 r0 restored", rf[0], 32'h1000);
    chk("R4 r1 restored", rf[1], 32'h1001);
    chk("R6 fixup r9", rf[9], 32'h55);
    chk("R5 enabled", irq_state, 1);

    // R6 no fix-up for kind 4
    fire_exc(3'd4, 2'd1, 32'h44, 0, 0, 28'h40, cnt);
    rf[0] = 32'h2; rf[1] = 32'h77;
    do_reti(cnt);
    chk("R6 no fixup r2", rf[2], 32'h1002);
    chk("R4 r0 kind4", rf[0], 32'h1000);
    chk("R4 pc kind4", last_pc, 28'h40);

    // R0-free external sweep: R7 and R8
    @(negedge clk); mask_we = 1; mask_wdata = 4'hF;
    @(negedge clk); mask_we = 0;
    for (int p = 1; p < 16; p++) begin
      int hi, g;
      hi = (p >= 8) ? 3 : (p >= 4) ? 2 : (p >= 2) ? 1 : 0;
      ret_pc = 28'h300 + 28'(p);
      @(negedge clk); ext_raise = 4'(p);
      @(negedge clk); ext_raise = 0;
      g = 0;
      while (!busy && g < 10) begin @(negedge clk); g++; end
      count_busy(cnt);
      chk("R7 ext busy", cnt, 2);
      chk("R7 ext vector", last_pc, 1);
      chk("R7 ext arg", rf[0], 32'(hi));
      chk("R7 ext ret word", mem[62], 32'h10000300 + 32'(p));
      chk("R7 pending held", ext_pending, 32'(p));
      do_reti(cnt);
      chk("R8 pending cleared", ext_pending, 0);
      chk("R8 enabled", irq_state, 1);
      chk("R4 ext r0 restored", rf[0], 32'h1000);
    end

    // R7 pending outside mask drops all
    @(negedge clk); mask_we = 1; mask_wdata = 4'b0001;
    @(negedge clk); mask_we = 0; ext_raise = 4'b0101;
    @(negedge clk); ext_raise = 0;
    repeat (3) @(negedge clk);
    chk("R7 dropped pending", ext_pending, 0);
    chk("R7 dropped no entry", sp, 64);
    chk("R7 dropped state", irq_state, 1);

    // R7 exception wins over external; external not checked while serving
    @(negedge clk); mask_we = 1; mask_wdata = 4'hF;
    @(negedge clk); mask_we = 0; ext_raise = 4'b0001;
    @(negedge clk); ext_raise = 0;
    exc_req = 1; exc_kind = 3'd6; exc_argc = 0; ret_pc = 28'h50;
    @(negedge clk); exc_req = 0;
    count_busy(cnt);
    chk("R7 exception first", last_pc, 6);
    repeat (3) @(negedge clk);
    chk("R7 pending kept serving", ext_pending, 1);
    chk("R7 still serving kind", irq_kind, 6);

    // R10 disable clears mask and pending
    pulse_cmd(0);
    chk("R10 disabled", irq_state, 0);
    chk("R10 pending cleared", ext_pending, 0);
    chk("R10 nest cleared", irq_nest, 0);
    pulse_cmd(1);
    chk("R10 enable from disabled", irq_state, 1);
    @(negedge clk); ext_raise = 4'b0100;
    @(negedge clk); ext_raise = 0;
    repeat (3) @(negedge clk);
    chk("R10 mask cleared drops", ext_pending, 0);
    chk("R10 no entry", irq_state, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule